// File: doc/BRIEF.md
# Double-Swath Line Buffer Pointer Manager

This block keeps the line pointers for a print line store in external memory that holds two swaths at once. The two swath slots form a two-entry ring. A writer fills one slot a line at a time. A reader works through the other slot, which has been sealed. The block produces the byte address of the line being written, the byte address of any line the reader asks for, and the copy addresses that carry overrun lines into the next slot. It also reports which slot each side is using, a full flag for the writer and an empty flag for the reader.

A swath has 208 lines, and each slot reserves 220 lines: the 208 swath lines plus a margin of 12. When the writer finishes line 208 of a slot, that slot is sealed and becomes readable. If the other slot is free, the writer moves to it after one stall cycle. If the other slot is still held, the writer keeps going into the margin of the slot it just sealed. Those extra lines are the first lines of the next swath. When the other slot is released, the writer jumps to it at the line index just past the carried lines. The block then issues one copy request per carried line, moving each line from the old margin to the head of the new slot.

The reader releases its slot in one of two ways: a finish pulse, or a blank pulse when the swath holds no black dots. If carried lines still have to be copied out of that slot, the release waits until the copy is done.

Top module: `swath_line_ptr`

## Requirements
- R1: After reset both slots are free, the writer is on slot 0 at line 0 (write address 0), the full flag is low, the empty flag is high and no copy is requested.
- R2: Write address = slot base + line index × 600 bytes, where slot 0 has base 0 and slot 1 has base 220 × 600 = 132000. Each write pulse accepted while full is low advances the line index by one.
- R3: One cycle after the 208th line of a slot is accepted, that slot becomes readable: empty goes low and the read slot output names that slot. The read address is the slot base plus the requested line × 600.
- R4: When the other slot is free at the end of a swath, full is high for exactly one cycle. The writer then moves to the other slot at line 0, with no copy requested.
- R5: When the other slot is still held at the end of a swath, further writes go into the margin at line indices 208 to 219 of the same slot. Full rises once all 12 margin lines are used.
- R6: When the held slot is released while the writer is in the margin, the writer moves to it at line index c, where c is the number of carried lines. The block then issues c copy requests, k = 0 to c−1, with source = old slot base + (208+k)×600 and destination = new slot base + k×600. Each request advances on an acknowledge.
- R7: A finish pulse while empty is low frees the read slot. The read slot output moves to the other slot, and empty reflects whether that slot is sealed.
- R8: A blank pulse frees the read slot in the same way as a finish pulse.
- R9: A release aimed at a slot whose carried lines are still being copied is held. Empty stays high while it is held, and the slot is freed once the last copy is acknowledged.
- R10: Finish and blank pulses that arrive while empty is high have no effect.
- R11: A write pulse while full is high is ignored, and the write address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_line_i | input | 1 | Writer commits the line at wr_addr_o |
| wr_addr_o | output | 19 | Byte address of the line being written |
| wr_slot_o | output | 1 | Slot the writer is filling |
| wr_full_o | output | 1 | Writer must hold its next line |
| rd_line_i | input | 8 | Line index the reader wants |
| rd_addr_o | output | 19 | Byte address of that line in the read slot |
| rd_slot_o | output | 1 | Slot the reader is draining |
| rd_empty_o | output | 1 | No sealed swath ready for the reader |
| rd_done_i | input | 1 | Reader has finished the swath |
| rd_blank_i | input | 1 | Swath judged all white; discard it |
| cp_valid_o | output | 1 | A carry copy is requested |
| cp_src_o | output | 19 | Source line address of the copy |
| cp_dst_o | output | 19 | Destination line address of the copy |
| cp_ack_i | input | 1 | Current copy is done |

## Verification
The hardest state to reach is a release that lands while carried lines are still waiting to be copied. To get there, both slots must first be sealed, and the writer must run through the whole margin. The reader must then free the older slot, which lets the writer switch and starts the copy. The stimulus fills slot 0 and slot 1, writes all 12 margin lines and releases slot 0. It then raises blank on slot 1 with the acknowledge held low, so the held release can be seen at the ports. A scoreboard queue holds the twelve expected source and destination pairs, and the monitor compares them one by one as acknowledges are given.

// File: rtl/swath_line_ptr_pkg.sv
package swath_line_ptr_pkg;
    localparam int unsigned DEF_SWATH_LINES  = 208;
    localparam int unsigned DEF_MARGIN_LINES = 12;
    localparam int unsigned DEF_LINE_BYTES   = 600;
    localparam int unsigned NUM_ADDR_PORTS   = 4;   // write, read, copy source, copy destination
endpackage

// File: rtl/swath_line_addr.sv
module swath_line_addr #(
    parameter int unsigned SLOT_LINES = 220,
    parameter int unsigned LINE_BYTES = 600,
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned ADDR_W     = 19
) (
    input  logic              slot_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] SLOT_BYTES = ADDR_W'(SLOT_LINES * LINE_BYTES);
    localparam logic [ADDR_W-1:0] STRIDE     = ADDR_W'(LINE_BYTES);

    logic [ADDR_W-1:0] base;

    always_comb begin
        base   = slot_i ? SLOT_BYTES : '0;
        addr_o = base + ADDR_W'(idx_i) * STRIDE;
    end
endmodule

// File: rtl/swath_carry_copy.sv
module swath_carry_copy #(
    parameter int unsigned CAR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CAR_W-1:0] count_i,
    input  logic             ack_i,
    output logic             valid_o,
    output logic [CAR_W-1:0] k_o
);
    typedef struct packed {
        logic [CAR_W-1:0] left;
        logic [CAR_W-1:0] k;
    } cp_state_t;

    cp_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (start_i) begin
            cs_d.left = count_i;
            cs_d.k    = '0;
        end else if (ack_i && cs_q.left != '0) begin
            cs_d.left = cs_q.left - 1'b1;
            cs_d.k    = cs_q.k + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign valid_o = (cs_q.left != '0);
    assign k_o     = cs_q.k;
endmodule

// File: rtl/swath_line_ptr.sv
module swath_line_ptr
    import swath_line_ptr_pkg::*;
#(
    parameter int unsigned SWATH_LINES  = DEF_SWATH_LINES,
    parameter int unsigned MARGIN_LINES = DEF_MARGIN_LINES,
    parameter int unsigned LINE_BYTES   = DEF_LINE_BYTES,
    localparam int unsigned SLOT_LINES  = SWATH_LINES + MARGIN_LINES,
    localparam int unsigned ADDR_W      = $clog2(2 * SLOT_LINES * LINE_BYTES),
    localparam int unsigned IDX_W       = $clog2(SLOT_LINES + 1),
    localparam int unsigned RDL_W       = $clog2(SWATH_LINES),
    localparam int unsigned CAR_W       = $clog2(MARGIN_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_line_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wr_slot_o,
    output logic              wr_full_o,
    input  logic [RDL_W-1:0]  rd_line_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_slot_o,
    output logic              rd_empty_o,
    input  logic              rd_done_i,
    input  logic              rd_blank_i,
    output logic              cp_valid_o,
    output logic [ADDR_W-1:0] cp_src_o,
    output logic [ADDR_W-1:0] cp_dst_o,
    input  logic              cp_ack_i
);
    typedef struct packed {
        logic [1:0]       ready;     // slot sealed and owned by the reader
        logic             wr_ptr;
        logic             rd_ptr;
        logic [IDX_W-1:0] wr_idx;
        logic             rel_pend;  // release requested, waiting for carry copy
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    logic             in_margin, other_sealed, switch_go, accept;
    logic             rel_req, rel_fire, cp_busy, cp_start;
    logic [CAR_W-1:0] cp_count, cp_k;

    // Address units: 0 write, 1 read, 2 copy source, 3 copy destination
    logic              a_slot [NUM_ADDR_PORTS];
    logic [IDX_W-1:0]  a_idx  [NUM_ADDR_PORTS];
    logic [ADDR_W-1:0] a_addr [NUM_ADDR_PORTS];

    always_comb begin
        in_margin    = st_q.wr_idx >= IDX_W'(SWATH_LINES);
        other_sealed = st_q.ready[~st_q.wr_ptr];
        wr_full_o    = in_margin && (st_q.wr_idx == IDX_W'(SLOT_LINES) || !other_sealed);
        switch_go    = in_margin && !other_sealed && !cp_busy;
        accept       = wr_line_i && !wr_full_o;
        rd_empty_o   = !st_q.ready[st_q.rd_ptr] || st_q.rel_pend;
        rel_req      = (rd_done_i || rd_blank_i) && !rd_empty_o;
        rel_fire     = (st_q.rel_pend || rel_req) && !cp_busy;
        cp_start     = switch_go;
        cp_count     = CAR_W'(st_q.wr_idx - IDX_W'(SWATH_LINES));

        st_d = st_q;
        if (rel_fire) begin
            st_d.ready[st_q.rd_ptr] = 1'b0;
            st_d.rd_ptr             = ~st_q.rd_ptr;
            st_d.rel_pend           = 1'b0;
        end else begin
            st_d.rel_pend = st_q.rel_pend || rel_req;
        end

        if (switch_go) begin
            st_d.wr_ptr = ~st_q.wr_ptr;
            st_d.wr_idx = st_q.wr_idx - IDX_W'(SWATH_LINES);
        end else if (accept) begin
            st_d.wr_idx = st_q.wr_idx + 1'b1;
            if (st_q.wr_idx == IDX_W'(SWATH_LINES - 1))
                st_d.ready[st_q.wr_ptr] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    swath_carry_copy #(.CAR_W(CAR_W)) u_copy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (cp_start),
        .count_i (cp_count),
        .ack_i   (cp_ack_i),
        .valid_o (cp_busy),
        .k_o     (cp_k)
    );

    always_comb begin
        a_slot[0] = st_q.wr_ptr;
        a_idx[0]  = st_q.wr_idx;
        a_slot[1] = st_q.rd_ptr;
        a_idx[1]  = IDX_W'(rd_line_i);
        a_slot[2] = ~st_q.wr_ptr;
        a_idx[2]  = IDX_W'(SWATH_LINES) + IDX_W'(cp_k);
        a_slot[3] = st_q.wr_ptr;
        a_idx[3]  = IDX_W'(cp_k);
    end

    for (genvar g = 0; g < NUM_ADDR_PORTS; g++) begin : g_addr
        swath_line_addr #(
            .SLOT_LINES (SLOT_LINES),
            .LINE_BYTES (LINE_BYTES),
            .IDX_W      (IDX_W),
            .ADDR_W     (ADDR_W)
        ) u_addr (
            .slot_i (a_slot[g]),
            .idx_i  (a_idx[g]),
            .addr_o (a_addr[g])
        );
    end

    assign wr_addr_o  = a_addr[0];
    assign rd_addr_o  = a_addr[1];
    assign cp_src_o   = a_addr[2];
    assign cp_dst_o   = a_addr[3];
    assign wr_slot_o  = st_q.wr_ptr;
    assign rd_slot_o  = st_q.rd_ptr;
    assign cp_valid_o = cp_busy;
endmodule

// File: rtl/swath_line_ptr_chk.sv
module swath_line_ptr_chk #(
    parameter int unsigned SWATH_LINES = 208,
    parameter int unsigned SLOT_LINES  = 220,
    parameter int unsigned LINE_BYTES  = 600,
    parameter int unsigned ADDR_W      = 19,
    parameter int unsigned IDX_W       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_line_i,
    input logic              wr_full_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic              wr_slot_o,
    input logic              rd_slot_o,
    input logic              rd_empty_o,
    input logic              cp_valid_o,
    input logic [1:0]        ready,
    input logic [IDX_W-1:0]  wr_idx
);
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_line_i && !wr_full_o) |=> (wr_addr_o == $past(wr_addr_o) + ADDR_W'(LINE_BYTES))); // R2

    AST_READER_ON_SEALED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_empty_o |-> ready[rd_slot_o]); // R3

    AST_BODY_SLOT_UNSEALED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx < IDX_W'(SWATH_LINES)) |-> !ready[wr_slot_o]); // R4

    AST_IDX_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idx <= IDX_W'(SLOT_LINES)); // R5

    AST_FULL_AT_MARGIN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx == IDX_W'(SLOT_LINES)) |-> wr_full_o); // R5

    AST_COPY_AFTER_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_valid_o) |-> (wr_slot_o != $past(wr_slot_o))); // R6

    AST_COPY_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cp_valid_o |-> (ready[~wr_slot_o] && rd_slot_o != wr_slot_o)); // R9

    AST_FULL_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_line_i && wr_full_o && ready[~wr_slot_o]) |=> $stable(wr_addr_o)); // R11
endmodule

bind swath_line_ptr swath_line_ptr_chk #(
    .SWATH_LINES (SWATH_LINES),
    .SLOT_LINES  (SLOT_LINES),
    .LINE_BYTES  (LINE_BYTES),
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_line_i  (wr_line_i),
    .wr_full_o  (wr_full_o),
    .wr_addr_o  (wr_addr_o),
    .wr_slot_o  (wr_slot_o),
    .rd_slot_o  (rd_slot_o),
    .rd_empty_o (rd_empty_o),
    .cp_valid_o (cp_valid_o),
    .ready      (st_q.ready),
    .wr_idx     (st_q.wr_idx)
);

// File: tb/swath_line_ptr_bench.sv
module swath_line_ptr_bench;
    localparam int SW    = 208;
    localparam int MG    = 12;
    localparam int LB    = 600;
    localparam int BASE1 = (SW + MG) * LB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_line_i = 1'b0;
    logic [18:0] wr_addr_o;
    logic        wr_slot_o, wr_full_o;
    logic [7:0]  rd_line_i = '0;
    logic [18:0] rd_addr_o;
    logic        rd_slot_o, rd_empty_o;
    logic        rd_done_i = 1'b0, rd_blank_i = 1'b0;
    logic        cp_valid_o;
    logic [18:0] cp_src_o, cp_dst_o;
    logic        cp_ack_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct { int src; int dst; } copy_item_t;
    copy_item_t exp_q[$];

    always #5 clk = ~clk;

    swath_line_ptr u_swath_line_ptr (.*);

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_lines(int n);
        for (int i = 0; i < n; i++) begin
            wr_line_i = 1'b1;
            tick();
        end
        wr_line_i = 1'b0;
    endtask

    task automatic push_copies(int c, int old_base, int new_base);
        for (int k = 0; k < c; k++) begin
            copy_item_t it;
            it.src = old_base + (SW + k) * LB;
            it.dst = new_base + k * LB;
            exp_q.push_back(it);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: pops one expected copy per acknowledged request (R6)
    always @(negedge clk) begin
        if (rst_n && cp_valid_o && cp_ack_i) begin
            if (exp_q.size() == 0) begin
                check("R6", "unexpected copy src", int'(cp_src_o), -1);
            end else begin
                copy_item_t it;
                it = exp_q.pop_front();
                check("R6", "copy src", int'(cp_src_o), it.src);
                check("R6", "copy dst", int'(cp_dst_o), it.dst);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1", "wr_slot", int'(wr_slot_o), 0);
        check("R1", "wr_addr", int'(wr_addr_o), 0);
        check("R1", "full", int'(wr_full_o), 0);
        check("R1", "empty", int'(rd_empty_o), 1);
        check("R1", "cp_valid", int'(cp_valid_o), 0);

        write_lines(3);
        check("R2", "wr_addr after 3 lines", int'(wr_addr_o), 3 * LB);

        // R10: finish pulse while empty must not latch
        rd_done_i = 1'b1; tick(); rd_done_i = 1'b0;
        check("R10", "empty after early done", int'(rd_empty_o), 1);

        write_lines(SW - 3);
        check("R3", "empty after 208 lines", int'(rd_empty_o), 0);
        check("R10", "early done left no release", int'(rd_slot_o), 0);
        check("R4", "one stall cycle", int'(wr_full_o), 1);
        rd_line_i = 8'd5;
        #1;
        check("R3", "rd_addr line 5", int'(rd_addr_o), 5 * LB);
        tick();
        check("R4", "writer moved slot", int'(wr_slot_o), 1);
        check("R4", "wr_addr slot1 line0", int'(wr_addr_o), BASE1);
        check("R4", "full released", int'(wr_full_o), 0);
        check("R4", "no copy", int'(cp_valid_o), 0);

        write_lines(SW);
        check("R5", "margin not full", int'(wr_full_o), 0);
        check("R5", "margin addr", int'(wr_addr_o), BASE1 + SW * LB);
        check("R5", "writer stays slot1", int'(wr_slot_o), 1);
        write_lines(MG);
        check("R5", "full after margin", int'(wr_full_o), 1);
        check("R5", "addr at margin end", int'(wr_addr_o), BASE1 + (SW + MG) * LB);
        write_lines(1);
        check("R11", "write while full ignored", int'(wr_addr_o), BASE1 + (SW + MG) * LB);

        push_copies(MG, BASE1, 0);
        rd_done_i = 1'b1; tick(); rd_done_i = 1'b0;
        check("R7", "read slot advanced", int'(rd_slot_o), 1);
        check("R7", "slot1 readable", int'(rd_empty_o), 0);
        tick();
        check("R6", "writer on slot0", int'(wr_slot_o), 0);
        check("R6", "wr_addr after carry", int'(wr_addr_o), MG * LB);
        check("R6", "copy requested", int'(cp_valid_o), 1);

        rd_blank_i = 1'b1; tick(); rd_blank_i = 1'b0;
        check("R9", "empty while held", int'(rd_empty_o), 1);
        check("R9", "read slot held", int'(rd_slot_o), 1);
        tick();
        check("R9", "still held", int'(rd_slot_o), 1);

        cp_ack_i = 1'b1;
        repeat (MG) tick();
        cp_ack_i = 1'b0;
        check("R6", "copies done", int'(cp_valid_o), 0);
        tick();
        check("R8", "blank freed slot1", int'(rd_slot_o), 0);
        check("R8", "empty after blank", int'(rd_empty_o), 1);
        check("R6", "all copies seen", exp_q.size(), 0);

        write_lines(SW - MG);
        check("R3", "slot0 sealed", int'(rd_empty_o), 0);
        check("R3", "read slot 0", int'(rd_slot_o), 0);
        check("R4", "stall again", int'(wr_full_o), 1);
        tick();
        check("R4", "writer to slot1", int'(wr_slot_o), 1);
        check("R4", "slot1 line0", int'(wr_addr_o), BASE1);
        check("R4", "no carry copy", int'(cp_valid_o), 0);

        summary();
        $finish;
    end
endmodule